// File: doc/BRIEF.md
# SPI Serial EEPROM Slave

This block is an SPI mode-0 target that behaves like a small byte-wide serial EEPROM of up to 512 bytes, held in an on-chip register array. A host selects it by pulling the active-low chip select, shifts in an 8-bit instruction, and then runs the address and data phases that the instruction calls for. Every field moves most significant bit first. A write-enable latch, two block-protect bits and a busy flag make up the status byte that the host can poll.

All pins are sampled with a fast system clock through a synchronizer, so the host's serial clock must run well below the system clock. Program operations are staged while chip select is low and committed when it rises. That commit starts an internal write cycle of a programmable number of system clocks. During the cycle the busy output is high and only a status read is honoured.

Top module: `eeprom_slave`

## Requirements
- R1: After reset the busy output is 0, MISO is 0, and a status read returns 8'h00 (latch clear, protection off).
- R2: Instruction 8'b0000x110 sets the write-enable latch only while wp_n is 1. Instruction 8'b0000x100 clears the latch for either level of wp_n.
- R3: Instruction 8'b0000x101 returns the status byte MSB first, repeating it for as long as SCK keeps running. Outside a write cycle the byte is {4'b0000, BP1, BP0, WEN, 1'b0}: bit 1 is the latch and bits 3:2 are the protect bits.
- R4: Raising chip select at the end of an accepted program frame starts a write cycle. busy is high for exactly WRITE_CYCLES clocks, and a status byte loaded in that window reads 8'hFF.
- R5: Instruction 8'b0000x001 followed by a data byte loads BP1/BP0 from data bits 3:2 at chip-select rise, but only if the latch was set at decode. Otherwise it has no effect.
- R6: Instruction 8'b0000A011 followed by an address byte reads from address {A, addr}, where A is opcode bit 3. Further bytes come from sequential addresses, and the address wraps from DEPTH-1 to 0.
- R7: Instruction 8'b0000A010 followed by an address byte and data bytes writes the data, but only if the latch was set at decode. Otherwise the array is unchanged.
- R8: Write data bytes step through a PAGE-byte page and wrap to the page start, never leaving the page.
- R9: The write-enable latch reads 0 once a write cycle ends.
- R10: During a write cycle any instruction other than the status read is ignored. A read returns zeros, and a write leaves the array unchanged.
- R11: MISO is 0 while chip select is high.
- R12: Protect bits 1, 2 and 3 block writes at or above 3/4 of DEPTH, 1/2 of DEPTH and 0 respectively. Bytes in a blocked range are dropped, and writes below the range still land.
- R13: An instruction whose upper nibble is not 0000 is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the SPI pins and times the write cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | SPI serial clock, idles low |
| cs_n | input | 1 | Active-low chip select |
| mosi | input | 1 | Serial data from host |
| wp_n | input | 1 | Write protect; low blocks the latch-set instruction |
| miso | output | 1 | Serial data to host, 0 when deselected |
| busy | output | 1 | High during an internal write cycle |

## Verification
The internal write cycle can overlap a host frame. Two things happen in the same cycle there: the countdown ends and clears the write-enable latch, while a status byte is loaded into the shift register at a byte boundary. The bench provokes this by starting a multi-byte status read right after a write commits, with the write cycle stretched to about two byte times. It judges the first status byte to be 8'hFF, each middle byte to be either 8'hFF or the idle value, and the last byte to be the idle value 8'h00 with the latch already cleared.

// File: rtl/eeprom_pkg.sv
package eeprom_pkg;

   typedef enum logic [2:0] {
      ST_CMD,
      ST_ADDR,
      ST_RD,
      ST_STAT,
      ST_WSR,
      ST_WR,
      ST_SKIP
   } ee_state_e;

   // low three opcode bits, upper nibble must be zero
   localparam logic [2:0] OPC_SETWE = 3'b110;
   localparam logic [2:0] OPC_CLRWE = 3'b100;
   localparam logic [2:0] OPC_STAT  = 3'b101;
   localparam logic [2:0] OPC_WSTAT = 3'b001;
   localparam logic [2:0] OPC_READ  = 3'b011;
   localparam logic [2:0] OPC_WRITE = 3'b010;

endpackage

// File: rtl/ee_pin_sync.sv
module ee_pin_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sck,
   input  logic cs_n,
   input  logic mosi,
   output logic sck_rise,
   output logic sck_fall,
   output logic cs_fall,
   output logic cs_rise,
   output logic cs_act,
   output logic mosi_s
);
   // bit 2 = sck, bit 1 = cs_n, bit 0 = mosi
   localparam logic [2:0] IDLE_PINS = 3'b010;

   if (STAGES < 2) begin : g_bad
      $error("ee_pin_sync: STAGES must be at least 2");
   end

   logic [2:0] chain [STAGES];
   logic [2:0] prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[0] <= IDLE_PINS;
      else        chain[0] <= {sck, cs_n, mosi};
   end

   for (genvar g = 1; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[g] <= IDLE_PINS;
         else        chain[g] <= chain[g-1];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= IDLE_PINS;
      else        prev <= chain[STAGES-1];
   end

   wire [2:0] cur = chain[STAGES-1];

   assign sck_rise = cur[2] & ~prev[2];
   assign sck_fall = ~cur[2] & prev[2];
   assign cs_fall  = ~cur[1] & prev[1];
   assign cs_rise  = cur[1] & ~prev[1];
   assign cs_act   = ~cur[1];
   assign mosi_s   = cur[0];
endmodule

// File: rtl/ee_timer.sv
module ee_timer #(
   parameter int CYCLES = 40
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy,
   output logic done
);
   localparam int CW = $clog2(CYCLES + 1);

   if (CYCLES < 1) begin : g_bad
      $error("ee_timer: CYCLES must be positive");
   end

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt <= '0;
      else if (start && !busy) cnt <= CW'(CYCLES);
      else if (busy)           cnt <= cnt - CW'(1);
   end

   assign busy = (cnt != '0);
   assign done = (cnt == CW'(1));
endmodule

// File: rtl/ee_array.sv
module ee_array #(
   parameter int DEPTH = 512,
   parameter int AW    = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [7:0]    wdata,
   input  logic [AW-1:0] raddr,
   output logic [7:0]    rdata
);
   logic [7:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (we) cells[waddr] <= wdata;
   end

   assign rdata = cells[raddr];
endmodule

// File: rtl/eeprom_slave.sv
module eeprom_slave
   import eeprom_pkg::*;
#(
   parameter int DEPTH        = 512,
   parameter int PAGE         = 16,
   parameter int WRITE_CYCLES = 40,
   parameter int SYNC_STAGES  = 2,
   parameter bit PROTECT_EN   = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sck,
   input  logic cs_n,
   input  logic mosi,
   input  logic wp_n,
   output logic miso,
   output logic busy
);
   localparam int AW = $clog2(DEPTH);
   localparam int PW = $clog2(PAGE);
   localparam logic [AW-1:0] A_ONE    = AW'(1);
   localparam logic [PW-1:0] P_ONE    = PW'(1);
   localparam logic [PW-1:0] P_LAST   = PW'(PAGE - 1);
   localparam int            LIM_QTR  = DEPTH - DEPTH / 4;
   localparam int            LIM_HALF = DEPTH / 2;

   if (DEPTH < 16 || DEPTH > 512 || (1 << AW) != DEPTH) begin : g_bad_depth
      $error("eeprom_slave: DEPTH must be a power of two in 16..512");
   end
   if (PAGE < 2 || PAGE > DEPTH || (1 << PW) != PAGE) begin : g_bad_page
      $error("eeprom_slave: PAGE must be a power of two no larger than DEPTH");
   end
   if (WRITE_CYCLES < PAGE) begin : g_bad_cyc
      $error("eeprom_slave: WRITE_CYCLES must cover one page commit");
   end

   logic sck_rise, sck_fall, cs_fall, cs_rise, cs_act, mosi_s;

   ee_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk, .rst_n, .sck, .cs_n, .mosi,
      .sck_rise, .sck_fall, .cs_fall, .cs_rise, .cs_act, .mosi_s
   );

   ee_state_e       st;
   logic [2:0]      bitcnt;
   logic [7:0]      rx, tx;
   logic [AW-1:0]   addr;
   logic            a8, is_rd;
   logic            wen_q;
   logic [1:0]      bp_q, bp_new;
   logic            wsr_pend;
   logic [7:0]      pbuf [PAGE];
   logic [PAGE-1:0] pvalid;
   logic [AW-PW-1:0] page_q;
   logic [PW-1:0]   cidx;
   logic            commit_on;
   logic            tmr_done, start;
   logic [7:0]      rd_data;

   wire [7:0] byte_in  = {rx[6:0], mosi_s};
   wire       byte_end = sck_rise && (bitcnt == 3'd7);
   wire [8:0] addr_full = {a8, byte_in};
   wire [7:0] status   = busy ? 8'hFF : {4'h0, bp_q, wen_q, 1'b0};

   assign start = cs_rise && !busy &&
                  ((st == ST_WR && |pvalid) || (st == ST_WSR && wsr_pend));

   ee_timer #(.CYCLES(WRITE_CYCLES)) u_tmr (
      .clk, .rst_n, .start, .busy, .done(tmr_done)
   );

   // commit path: one staged byte per clock at the start of the write cycle
   wire [AW-1:0] waddr = {page_q, cidx};
   logic allow;

   if (PROTECT_EN) begin : g_prot
      always_comb begin
         unique case (bp_q)
            2'd0:    allow = 1'b1;
            2'd1:    allow = int'(waddr) < LIM_QTR;
            2'd2:    allow = int'(waddr) < LIM_HALF;
            default: allow = 1'b0;
         endcase
      end
   end else begin : g_noprot
      assign allow = 1'b1;
   end

   ee_array #(.DEPTH(DEPTH), .AW(AW)) u_mem (
      .clk,
      .we    (commit_on && pvalid[cidx] && allow),
      .waddr,
      .wdata (pbuf[cidx]),
      .raddr (addr),
      .rdata (rd_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_CMD;
         bitcnt    <= '0;
         rx        <= '0;
         tx        <= '0;
         addr      <= '0;
         a8        <= 1'b0;
         is_rd     <= 1'b0;
         wen_q     <= 1'b0;
         bp_q      <= '0;
         bp_new    <= '0;
         wsr_pend  <= 1'b0;
         pvalid    <= '0;
         page_q    <= '0;
         cidx      <= '0;
         commit_on <= 1'b0;
         for (int i = 0; i < PAGE; i++) pbuf[i] <= '0;
      end else begin
         if (tmr_done) wen_q <= 1'b0;
         if (start) begin
            if (st == ST_WSR) bp_q <= bp_new;
            else begin
               commit_on <= 1'b1;
               cidx      <= '0;
            end
         end
         if (commit_on) begin
            cidx <= cidx + P_ONE;
            if (cidx == P_LAST) commit_on <= 1'b0;
         end

         if (cs_fall || cs_rise) begin
            st       <= ST_CMD;
            bitcnt   <= '0;
            wsr_pend <= 1'b0;
         end else if (cs_act) begin
            if (sck_rise) begin
               rx     <= byte_in;
               bitcnt <= bitcnt + 3'd1;
            end
            if (byte_end) begin
               unique case (st)
                  ST_CMD: begin
                     if (byte_in[7:4] != 4'h0) st <= ST_SKIP;
                     else if (busy && byte_in[2:0] != OPC_STAT) st <= ST_SKIP;
                     else begin
                        st <= ST_SKIP;
                        case (byte_in[2:0])
                           OPC_SETWE: if (wp_n) wen_q <= 1'b1;
                           OPC_CLRWE: wen_q <= 1'b0;
                           OPC_STAT:  st <= ST_STAT;
                           OPC_WSTAT: if (wen_q) st <= ST_WSR;
                           OPC_READ: begin
                              a8    <= byte_in[3];
                              is_rd <= 1'b1;
                              st    <= ST_ADDR;
                           end
                           OPC_WRITE: if (wen_q) begin
                              a8     <= byte_in[3];
                              is_rd  <= 1'b0;
                              pvalid <= '0;
                              st     <= ST_ADDR;
                           end
                           default: ;
                        endcase
                     end
                  end
                  ST_ADDR: begin
                     addr   <= addr_full[AW-1:0];
                     page_q <= addr_full[AW-1:PW];
                     st     <= is_rd ? ST_RD : ST_WR;
                  end
                  ST_WSR: begin
                     bp_new   <= byte_in[3:2];
                     wsr_pend <= 1'b1;
                  end
                  ST_WR: begin
                     pbuf[addr[PW-1:0]]   <= byte_in;
                     pvalid[addr[PW-1:0]] <= 1'b1;
                     addr[PW-1:0]         <= addr[PW-1:0] + P_ONE;
                  end
                  default: ;
               endcase
            end
            if (sck_fall) begin
               if (bitcnt == 3'd0 && st == ST_RD) begin
                  tx   <= rd_data;
                  addr <= addr + A_ONE;
               end else if (bitcnt == 3'd0 && st == ST_STAT) begin
                  tx <= status;
               end else begin
                  tx <= {tx[6:0], 1'b0};
               end
            end
         end
      end
   end

   assign miso = cs_act && (st == ST_RD || st == ST_STAT) && tx[7];
endmodule

// File: rtl/ee_slave_chk.sv
module ee_slave_chk #(
   parameter int WRITE_CYCLES = 40
) (
   input logic clk,
   input logic rst_n,
   input logic cs_n,
   input logic wp_n,
   input logic miso,
   input logic busy,
   input logic wen
);
   logic [31:0] bcnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    bcnt <= '0;
      else if (busy) bcnt <= bcnt + 32'd1;
      else           bcnt <= '0;
   end

   // R11: deselected for long enough to pass the synchronizer
   a_r11_miso_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3)) |-> !miso);

   // R4: write cycle length in clocks
   a_r4_busy_len: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && $past(busy)) |-> (bcnt == 32'(WRITE_CYCLES)));

   // R9: latch cleared when the cycle ends
   a_r9_wen_clear: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> !wen);

   // R2: latch set only with write protect released
   a_r2_wren_wp: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wen) |-> $past(wp_n));

   // R10: no latch set during a write cycle
   a_r10_busy_wren: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wen) |-> !$past(busy));
endmodule

bind eeprom_slave ee_slave_chk #(.WRITE_CYCLES(WRITE_CYCLES)) u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .cs_n  (cs_n),
   .wp_n  (wp_n),
   .miso  (miso),
   .busy  (busy),
   .wen   (wen_q)
);

// File: tb/sim_eeprom_slave.sv
`timescale 1ns/1ps
module sim_eeprom_slave;
   localparam int HALF = 6;
   localparam int WC   = 200;

   logic clk = 1'b0, rst_n = 1'b0;
   logic sck = 1'b0, cs_n = 1'b1, mosi = 1'b0, wp_n = 1'b1;
   logic miso, busy;
   int   n_chk = 0, n_fail = 0;
   bit   ended = 1'b0;

   always #5 clk = ~clk;

   eeprom_slave #(.WRITE_CYCLES(WC)) u0 (
      .clk, .rst_n, .sck, .cs_n, .mosi, .wp_n, .miso, .busy
   );

   // {addr[8:0], data[7:0]}
   localparam logic [16:0] VEC [7] = '{
      {9'h000, 8'h5A}, {9'h001, 8'hA5}, {9'h0FF, 8'h3C}, {9'h100, 8'hC3},
      {9'h1FF, 8'h96}, {9'h021, 8'h11}, {9'h180, 8'hE7}
   };

   task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
      end
   endtask

   task automatic xfer(input logic [7:0] b, output logic [7:0] r);
      for (int i = 7; i >= 0; i--) begin
         mosi = b[i];
         repeat (HALF) @(negedge clk);
         r[i] = miso;
         sck = 1'b1;
         repeat (HALF) @(negedge clk);
         sck = 1'b0;
      end
   endtask

   task automatic cs_lo;
      cs_n = 1'b0;
      repeat (6) @(negedge clk);
   endtask

   task automatic cs_hi;
      repeat (6) @(negedge clk);
      cs_n = 1'b1;
      repeat (6) @(negedge clk);
   endtask

   task automatic cmd1(input logic [7:0] op);
      logic [7:0] d;
      cs_lo; xfer(op, d); cs_hi;
   endtask

   task automatic wr_byte(input logic [8:0] a, input logic [7:0] v);
      logic [7:0] d;
      cs_lo;
      xfer({4'h0, a[8], 3'b010}, d);
      xfer(a[7:0], d);
      xfer(v, d);
      cs_hi;
   endtask

   task automatic rd_byte(input logic [8:0] a, output logic [7:0] v);
      logic [7:0] d;
      cs_lo;
      xfer({4'h0, a[8], 3'b011}, d);
      xfer(a[7:0], d);
      xfer(8'h00, v);
      cs_hi;
   endtask

   task automatic rdsr(output logic [7:0] s);
      logic [7:0] d;
      cs_lo; xfer(8'h05, d); xfer(8'h00, s); cs_hi;
   endtask

   task automatic wsr(input logic [7:0] v);
      logic [7:0] d;
      cs_lo; xfer(8'h01, d); xfer(v, d); cs_hi;
   endtask

   task automatic wait_ready;
      for (int i = 0; i < 2000 && busy; i++) @(negedge clk);
      repeat (4) @(negedge clk);
   endtask

   initial begin
      #2_000_000;
      if (!ended) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=00 expected=01");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      logic [7:0] s, v, d, s0, s1, s2;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);

      // R1 reset state
      chk(busy == 1'b0, "R1 busy", {7'b0, busy}, 8'h00);
      chk(miso == 1'b0, "R11 miso idle", {7'b0, miso}, 8'h00);
      rdsr(s);
      chk(s == 8'h00, "R1 R3 status after reset", s, 8'h00);

      // R2 write protect gates the latch set
      wp_n = 1'b0; cmd1(8'h06); rdsr(s);
      chk(s == 8'h00, "R2 set blocked by wp", s, 8'h00);
      wp_n = 1'b1; cmd1(8'h0E); rdsr(s);
      chk(s == 8'h02, "R2 R3 set with wp high", s, 8'h02);
      wp_n = 1'b0; cmd1(8'h04); rdsr(s);
      chk(s == 8'h00, "R2 clear with wp low", s, 8'h00);
      wp_n = 1'b1;

      // R13 nonzero upper nibble
      cmd1(8'h16); rdsr(s);
      chk(s == 8'h00, "R13 bad opcode ignored", s, 8'h00);

      // vector table: write then read back
      foreach (VEC[k]) begin
         cmd1(8'h06);
         wr_byte(VEC[k][16:8], VEC[k][7:0]);
         chk(busy == 1'b1, "R4 busy after commit", {7'b0, busy}, 8'h01);
         wait_ready;
         rdsr(s);
         chk(s == 8'h00, "R9 latch cleared", s, 8'h00);
         rd_byte(VEC[k][16:8], v);
         chk(v == VEC[k][7:0], "R6 R7 readback", v, VEC[k][7:0]);
         chk(miso == 1'b0, "R11 miso after frame", {7'b0, miso}, 8'h00);
      end

      // R6 sequential read with wrap at the top
      cs_lo;
      xfer(8'h0B, d); xfer(8'hFF, d); xfer(8'h00, s0); xfer(8'h00, s1);
      cs_hi;
      chk(s0 == 8'h96, "R6 seq byte0", s0, 8'h96);
      chk(s1 == 8'h5A, "R6 wrap to 0", s1, 8'h5A);

      // R4 status during write cycle, overlapping its end
      cmd1(8'h06);
      wr_byte(9'h040, 8'h42);
      cs_lo;
      xfer(8'h05, d); xfer(8'h00, s0); xfer(8'h00, s1); xfer(8'h00, s2);
      cs_hi;
      chk(s0 == 8'hFF, "R4 status busy", s0, 8'hFF);
      chk(s1 == 8'hFF || s1 == 8'h00, "R4 status at boundary", s1, 8'hFF);
      chk(s2 == 8'h00, "R9 status after cycle", s2, 8'h00);
      wait_ready;

      // R10 write during a write cycle is ignored
      cmd1(8'h06);
      wr_byte(9'h020, 8'h20);
      wr_byte(9'h021, 8'h77);
      wait_ready;
      rd_byte(9'h021, v);
      chk(v == 8'h11, "R10 write while busy", v, 8'h11);
      // R10 read during a write cycle returns zero
      cmd1(8'h06);
      wr_byte(9'h041, 8'h41);
      rd_byte(9'h000, v);
      chk(v == 8'h00, "R10 read while busy", v, 8'h00);
      wait_ready;

      // R7 write without latch
      wr_byte(9'h001, 8'hFF);
      wait_ready;
      rd_byte(9'h001, v);
      chk(v == 8'hA5, "R7 write without latch", v, 8'hA5);

      // R8 page wrap
      cmd1(8'h06);
      cs_lo;
      xfer(8'h02, d); xfer(8'h3E, d); xfer(8'h01, d); xfer(8'h02, d); xfer(8'h03, d);
      cs_hi;
      wait_ready;
      rd_byte(9'h030, v);
      chk(v == 8'h03, "R8 wrapped byte", v, 8'h03);
      rd_byte(9'h03E, v);
      chk(v == 8'h01, "R8 first byte", v, 8'h01);
      rd_byte(9'h03F, v);
      chk(v == 8'h02, "R8 second byte", v, 8'h02);
      rd_byte(9'h040, v);
      chk(v == 8'h42, "R8 next page untouched", v, 8'h42);

      // R5 status write
      wsr(8'h0C); wait_ready; rdsr(s);
      chk(s == 8'h00, "R5 status write without latch", s, 8'h00);
      cmd1(8'h06); wsr(8'h04); wait_ready; rdsr(s);
      chk(s == 8'h04, "R5 R3 bp0 set", s, 8'h04);

      // R12 protection ranges
      cmd1(8'h06); wr_byte(9'h180, 8'h00); wait_ready;
      rd_byte(9'h180, v);
      chk(v == 8'hE7, "R12 top quarter blocked", v, 8'hE7);
      cmd1(8'h06); wr_byte(9'h17F, 8'h55); wait_ready;
      rd_byte(9'h17F, v);
      chk(v == 8'h55, "R12 below quarter allowed", v, 8'h55);
      cmd1(8'h06); wsr(8'h08); wait_ready; rdsr(s);
      chk(s == 8'h08, "R5 bp1 set", s, 8'h08);
      cmd1(8'h06); wr_byte(9'h100, 8'h00); wait_ready;
      rd_byte(9'h100, v);
      chk(v == 8'hC3, "R12 top half blocked", v, 8'hC3);
      cmd1(8'h06); wsr(8'h0C); wait_ready;
      cmd1(8'h06); wr_byte(9'h000, 8'h00); wait_ready;
      rd_byte(9'h000, v);
      chk(v == 8'h5A, "R12 all blocked", v, 8'h5A);
      cmd1(8'h06); wsr(8'h00); wait_ready; rdsr(s);
      chk(s == 8'h00, "R5 protection cleared", s, 8'h00);
      chk(miso == 1'b0, "R11 miso final", {7'b0, miso}, 8'h00);

      ended = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule